// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block decides which interrupt a single CPU should take next. It covers a set of maskable vectors, a reset entry and a software trap entry. Software gives each maskable vector a 2-bit level through a small write port. Level 0 turns the vector off. Levels 1 to 3 enable it, and a higher number is more urgent. The lowest vector index wins among requests at the same level. The controller keeps the level of the handler now running. It offers a maskable request only when that request's level is strictly above the running level, so a more urgent handler can nest inside a less urgent one.

The low-numbered vectors take their requests from external pins. Each pin has its own edge detector, which can be set to rising, falling or both edges, and which latches a pending flag. The remaining vectors take level requests from internal peripherals. The reset entry and the trap entry rank above every maskable vector and ignore the running level. The CPU takes the offered vector with an acknowledge strobe and ends a handler with a return strobe. On acknowledge the controller saves the old level on an internal stack. On return it restores that level. Vector fetch and context stacking belong to the CPU.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Out of reset, `irq_req` is 1 and `irq_vec` is 0 (the reset entry), with `cur_lvl` 0. Once that entry is acknowledged it is never offered again, and `cur_lvl` stays 0.
- R2: Vector codes are 0 for reset, 1 for trap and 2+i for maskable vector i. A write with `cfg_we` high and `cfg_addr`=i sets the level of vector i to `cfg_wdata[1:0]`, where 0 means disabled. For i below NUM_EXT the same write sets the edge mode to `cfg_wdata[3:2]`: 0 rising, 1 falling, 2 or 3 both edges. The write takes effect from the next cycle.
- R3: A maskable vector is offered only if it is pending, its level is nonzero and its level is strictly greater than `cur_lvl`. Among the offered candidates the highest level wins.
- R4: Among pending enabled vectors at the same level, the lowest index is offered.
- R5: Acknowledging a maskable vector pushes the old `cur_lvl` and sets `cur_lvl` to that vector's level. Each `rti` pops the most recent saved level back into `cur_lvl`. `rti` with an empty stack has no effect.
- R6: A one-cycle `trap_req` pulse latches a trap request. It is offered as code 1 above all maskable vectors, whatever `cur_lvl` is. Acknowledging it pushes the old level and sets `cur_lvl` to 3. While the STACK_DEPTH-entry stack is full, the trap waits and is offered again after the next `rti`.
- R7: External vector e (e < NUM_EXT) becomes pending on the configured edge of `ext_pin[e]`. It stays pending until that vector is acknowledged.
- R8: Internal vector NUM_EXT+j follows `int_irq[j]` as a level request. Acknowledge does not clear it.
- R9: `ack` while `irq_req` is 0 has no effect. When `ack` and `rti` arrive together, the acknowledge is applied and the return is ignored.
- R10: An external edge seen while its vector is disabled is still latched. The vector is offered once a nonzero level is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| int_irq | input | NUM_VEC-NUM_EXT | Level requests from internal peripherals, bit j for vector NUM_EXT+j |
| ext_pin | input | NUM_EXT | Synchronous external request lines for vectors 0..NUM_EXT-1 |
| trap_req | input | 1 | Software trap pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(NUM_VEC) | Maskable vector index to configure |
| cfg_wdata | input | 4 | [1:0] level, [3:2] edge mode |
| ack | input | 1 | CPU takes the offered vector |
| rti | input | 1 | CPU returns from the current handler |
| irq_req | output | 1 | A vector is offered |
| irq_vec | output | $clog2(NUM_VEC+2) | Offered vector code |
| cur_lvl | output | 2 | Level of the running context |

## Verification
The assertions check every cycle that the reset entry comes first and only once, and that offered codes stay in range. They also check that a maskable acknowledge strictly raises the level, a trap acknowledge sets level 3, a return never raises it, and the level is unchanged when neither strobe acts. Which vector wins among ties and levels, the edge modes, the latching of disabled edges, holding a trap on a full stack and the ack-with-rti case depend on the configured state. Only the bench's scenarios show these. The bench sweeps every internal vector at every level and every external line in every edge mode.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int LVL_W = 2;
    localparam logic [LVL_W-1:0] LVL_TOP = 2'd3;
    localparam int VEC_RESET = 0;
    localparam int VEC_TRAP  = 1;
    localparam int VEC_BASE  = 2;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_BOTH  = 2'd2,
        EDGE_BOTH2 = 2'd3
    } edge_mode_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
    import irq_nest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    input  logic       clr,
    output logic       pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } det_t;

    det_t s_d, s_q;
    logic hit;

    always_comb begin
        case (edge_mode_e'(mode))
            EDGE_RISE: hit = pin & ~s_q.prev;
            EDGE_FALL: hit = ~pin & s_q.prev;
            default:   hit = pin ^ s_q.prev;
        endcase
        s_d.prev = pin;
        s_d.pend = (s_q.pend & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_nest_pkg::*;
#(
    parameter int NUM_VEC = 26,
    localparam int IDX_W  = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0]            req,
    input  logic [NUM_VEC-1:0][LVL_W-1:0] lvl,
    output logic                          found,
    output logic [IDX_W-1:0]              idx,
    output logic [LVL_W-1:0]              best
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (req[i] && (lvl[i] != '0) && (lvl[i] >= best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = lvl[i];
            end
        end
    end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] push_val,
    output logic [LVL_W-1:0] top,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][LVL_W-1:0] mem;
        logic [SP_W-1:0]             sp;
    } stk_t;

    stk_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        full  = (s_q.sp == SP_W'(DEPTH));
        empty = (s_q.sp == '0);
        top   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(s_q.sp) == k + 1) top = s_q.mem[k];
        end
        if (push && !full) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (int'(s_q.sp) == k) s_d.mem[k] = push_val;
            end
            s_d.sp = s_q.sp + 1'b1;
        end else if (pop && !empty) begin
            s_d.sp = s_q.sp - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_VEC     = 26,
    parameter int NUM_EXT     = 6,
    parameter int STACK_DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_VEC-NUM_EXT-1:0]   int_irq,
    input  logic [NUM_EXT-1:0]           ext_pin,
    input  logic                         trap_req,
    input  logic                         cfg_we,
    input  logic [$clog2(NUM_VEC)-1:0]   cfg_addr,
    input  logic [3:0]                   cfg_wdata,
    input  logic                         ack,
    input  logic                         rti,
    output logic                         irq_req,
    output logic [$clog2(NUM_VEC+2)-1:0] irq_vec,
    output logic [LVL_W-1:0]             cur_lvl
);
    localparam int IDX_W = $clog2(NUM_VEC);
    localparam int VEC_W = $clog2(NUM_VEC + 2);

    typedef struct packed {
        logic [NUM_VEC-1:0][LVL_W-1:0] lvl;
        logic [NUM_EXT-1:0][1:0]       mode;
        logic [LVL_W-1:0]              cur;
        logic                          rst_pend;
        logic                          trap_pend;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [NUM_VEC-1:0] req_vec;
    logic [NUM_EXT-1:0] ext_pend;
    logic [NUM_EXT-1:0] ext_clr;
    logic               cand_found;
    logic [IDX_W-1:0]   cand_idx;
    logic [LVL_W-1:0]   cand_lvl;
    logic [LVL_W-1:0]   stk_top;
    logic               stk_full, stk_empty;
    logic               trap_ok, take_mask;
    logic               sel_trap, sel_mask, ack_ok;
    logic               do_push, do_pop;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_src
        if (g < NUM_EXT) begin : g_ext
            irq_edge_det u_det (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (ext_pin[g]),
                .mode (s_q.mode[g]),
                .clr  (ext_clr[g]),
                .pend (ext_pend[g])
            );
            assign req_vec[g] = ext_pend[g];
            assign ext_clr[g] = ack_ok && sel_mask && (cand_idx == IDX_W'(g));
        end else begin : g_int
            assign req_vec[g] = int_irq[g-NUM_EXT];
        end
    end

    irq_prio_pick #(.NUM_VEC(NUM_VEC)) u_pick (
        .req  (req_vec),
        .lvl  (s_q.lvl),
        .found(cand_found),
        .idx  (cand_idx),
        .best (cand_lvl)
    );

    irq_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (do_push),
        .pop     (do_pop),
        .push_val(s_q.cur),
        .top     (stk_top),
        .full    (stk_full),
        .empty   (stk_empty)
    );

    always_comb begin
        trap_ok   = s_q.trap_pend && !stk_full;
        take_mask = cand_found && (cand_lvl > s_q.cur);
        sel_trap  = !s_q.rst_pend && trap_ok;
        sel_mask  = !s_q.rst_pend && !trap_ok && take_mask;
        irq_req   = s_q.rst_pend || trap_ok || take_mask;
        if (s_q.rst_pend)  irq_vec = VEC_W'(VEC_RESET);
        else if (trap_ok)  irq_vec = VEC_W'(VEC_TRAP);
        else               irq_vec = VEC_W'(cand_idx) + VEC_W'(VEC_BASE);
        ack_ok  = ack && irq_req;
        do_push = ack_ok && !s_q.rst_pend;
        do_pop  = rti && !ack_ok && !stk_empty;

        s_d = s_q;
        for (int k = 0; k < NUM_VEC; k++) begin
            if (cfg_we && int'(cfg_addr) == k) s_d.lvl[k] = cfg_wdata[1:0];
        end
        for (int k = 0; k < NUM_EXT; k++) begin
            if (cfg_we && int'(cfg_addr) == k) s_d.mode[k] = cfg_wdata[3:2];
        end
        s_d.trap_pend = (s_q.trap_pend && !(ack_ok && sel_trap)) || trap_req;
        if (ack_ok) begin
            if (s_q.rst_pend)  s_d.rst_pend = 1'b0;
            else if (sel_trap) s_d.cur = LVL_TOP;
            else               s_d.cur = cand_lvl;
        end else if (do_pop) begin
            s_d.cur = stk_top;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.rst_pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_lvl = s_q.cur;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int NUM_VEC = 26,
    parameter int VEC_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             rti,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [1:0]       cur_lvl
);
    logic reset_taken_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  reset_taken_q <= 1'b0;
        else if (ack && irq_req && irq_vec == '0)    reset_taken_q <= 1'b1;
    end

    // R1: reset entry offered until taken
    assert_reset_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_taken_q |-> (irq_req && irq_vec == '0));

    // R1: reset entry never comes back
    assert_reset_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reset_taken_q |-> !(irq_req && irq_vec == '0));

    // R2: code range
    assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_vec) < NUM_VEC + 2));

    // R5: maskable acknowledge raises the level strictly
    assert_mask_ack_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && int'(irq_vec) >= 2) |=> (cur_lvl > $past(cur_lvl)));

    // R5: a return never raises the level
    assert_rti_no_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !(ack && irq_req)) |=> (cur_lvl <= $past(cur_lvl)));

    // R6: trap acknowledge enters top level
    assert_trap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req && int'(irq_vec) == 1) |=> (cur_lvl == 2'd3));

    // R9: level unchanged without an effective strobe
    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack && irq_req) && !rti) |=> $stable(cur_lvl));
endmodule

bind irq_nest_ctrl irq_nest_chk #(
    .NUM_VEC(NUM_VEC),
    .VEC_W  ($clog2(NUM_VEC + 2))
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack    (ack),
    .rti    (rti),
    .irq_req(irq_req),
    .irq_vec(irq_vec),
    .cur_lvl(cur_lvl)
);

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;
    localparam int NV = 26;
    localparam int NE = 6;
    localparam int NI = NV - NE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] int_irq = '0;
    logic [NE-1:0] ext_pin = '0;
    logic          trap_req = 1'b0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [3:0]    cfg_wdata = '0;
    logic          ack = 1'b0;
    logic          rti = 1'b0;
    logic          irq_req;
    logic [4:0]    irq_vec;
    logic [1:0]    cur_lvl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_nest_ctrl #(.NUM_VEC(NV), .NUM_EXT(NE), .STACK_DEPTH(4)) u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .int_irq(int_irq), .ext_pin(ext_pin),
        .trap_req(trap_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ack(ack), .rti(rti),
        .irq_req(irq_req), .irq_vec(irq_vec), .cur_lvl(cur_lvl)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // offered code, or -1 when nothing is offered
    function automatic int offer();
        return irq_req ? int'(irq_vec) : -1;
    endfunction

    task automatic cfg(input int idx, input int lvl, input int mode);
        cfg_we = 1'b1; cfg_addr = 5'(idx); cfg_wdata = {2'(mode), 2'(lvl)};
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_rti();
        rti = 1'b1; tick(); rti = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        chk("R1 reset offer", offer(), 0);
        chk("R1 reset level", int'(cur_lvl), 0);
        do_ack();
        chk("R1 after reset ack", offer(), -1);
        chk("R1 level after reset ack", int'(cur_lvl), 0);

        // R3 R5 R8 sweep of internal vectors and levels
        for (int j = 0; j < NI; j++) begin
            for (int l = 1; l <= 3; l++) begin
                cfg(NE + j, l, 0);
                int_irq[j] = 1'b1;
                #1;
                chk("R3 offer internal", offer(), NE + j + 2);
                do_ack();
                chk("R5 level on ack", int'(cur_lvl), l);
                chk("R3 same level not offered", offer(), -1);
                do_rti();
                chk("R5 level on rti", int'(cur_lvl), 0);
                chk("R8 level request persists", offer(), NE + j + 2);
                int_irq[j] = 1'b0;
                cfg(NE + j, 0, 0);
                chk("R2 disabled", offer(), -1);
            end
        end

        // R4 tie and R3 higher level wins
        cfg(10, 2, 0); cfg(20, 2, 0);
        int_irq[10-NE] = 1'b1; int_irq[20-NE] = 1'b1;
        #1;
        chk("R4 tie lowest index", offer(), 12);
        cfg(20, 3, 0);
        chk("R3 higher level wins", offer(), 22);
        int_irq = '0; cfg(10, 0, 0); cfg(20, 0, 0);

        // R7 edge modes on every external line
        for (int e = 0; e < NE; e++) begin
            for (int m = 0; m < 4; m++) begin
                cfg(e, 2, m);
                ext_pin[e] = 1'b1;
                tick();
                if (m != 1) begin
                    chk("R7 rise pending", offer(), e + 2);
                    do_ack();
                    chk("R7 ack level", int'(cur_lvl), 2);
                    chk("R7 cleared on ack", offer(), -1);
                    do_rti();
                end else begin
                    chk("R7 rise ignored in fall mode", offer(), -1);
                end
                ext_pin[e] = 1'b0;
                tick();
                if (m != 0) begin
                    chk("R7 fall pending", offer(), e + 2);
                    do_ack();
                    do_rti();
                    chk("R7 cleared after fall", offer(), -1);
                end else begin
                    chk("R7 fall ignored in rise mode", offer(), -1);
                end
                cfg(e, 0, 0);
            end
        end

        // R10 edge latched while disabled
        ext_pin[3] = 1'b1; tick();
        chk("R10 disabled not offered", offer(), -1);
        cfg(3, 1, 0);
        chk("R10 offered once enabled", offer(), 5);
        do_ack(); do_rti();
        chk("R10 cleared", offer(), -1);
        ext_pin[3] = 1'b0; tick(); cfg(3, 0, 0);

        // R5 R6 nesting and full stack
        cfg(8, 1, 0); cfg(9, 2, 0); cfg(10, 3, 0);
        int_irq[8-NE] = 1'b1; #1;
        chk("R5 nest level1 offer", offer(), 10);
        do_ack();
        int_irq[9-NE] = 1'b1; #1;
        chk("R5 nest level2 offer", offer(), 11);
        do_ack();
        int_irq[10-NE] = 1'b1; #1;
        chk("R5 nest level3 offer", offer(), 12);
        do_ack();
        chk("R5 level 3", int'(cur_lvl), 3);
        chk("R3 nothing above 3", offer(), -1);
        trap_req = 1'b1; tick(); trap_req = 1'b0;
        chk("R6 trap offered at level 3", offer(), 1);
        do_ack();
        chk("R6 trap level", int'(cur_lvl), 3);
        trap_req = 1'b1; tick(); trap_req = 1'b0;
        chk("R6 trap held on full stack", offer(), -1);
        do_rti();
        chk("R6 level after pop", int'(cur_lvl), 3);
        chk("R6 trap offered after pop", offer(), 1);
        do_ack();
        int_irq = '0;
        do_rti(); chk("R5 pop 1", int'(cur_lvl), 3);
        do_rti(); chk("R5 pop 2", int'(cur_lvl), 2);
        do_rti(); chk("R5 pop 3", int'(cur_lvl), 1);
        do_rti(); chk("R5 pop 4", int'(cur_lvl), 0);
        do_rti(); chk("R5 rti on empty", int'(cur_lvl), 0);

        // R9 stray ack and ack with rti
        do_ack();
        chk("R9 ack without request", int'(cur_lvl), 0);
        int_irq[8-NE] = 1'b1; #1;
        do_ack();
        int_irq[8-NE] = 1'b0;
        int_irq[9-NE] = 1'b1; #1;
        ack = 1'b1; rti = 1'b1; tick(); ack = 1'b0; rti = 1'b0;
        chk("R9 ack wins over rti", int'(cur_lvl), 2);
        int_irq = '0;
        do_rti(); chk("R9 pop to 1", int'(cur_lvl), 1);
        do_rti(); chk("R9 pop to 0", int'(cur_lvl), 0);
        chk("R1 reset entry not repeated", offer(), -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule